// File: doc/BRIEF.md
# Receive Descriptor Write-back Engine

This block hands incoming Ethernet frames to a ring of receive buffer descriptors held in a shared descriptor memory. The receive ring occupies the descriptor slots that follow the transmit descriptors. Its first slot index equals the transmit descriptor count. Each descriptor is two 32-bit words: a length/status word at word address `2*index` and a buffer address word at `2*index+1`.

When the receive datapath signals the start of a frame, the engine reads the current descriptor's status word. If software has handed that descriptor to hardware (empty bit set), the engine fetches the buffer address and presents it to the datapath. When the frame ends, the engine applies the minimum and maximum length limits. It then encodes the error flags and writes the length, the status and a cleared empty bit back in a single memory write, and moves to the next descriptor. If the descriptor is still owned by software, the frame is discarded and a busy event is raised. Address filtering, the payload write and CRC checking are handled elsewhere; their results arrive as flag inputs.

Top module: `rx_desc_writeback`

## Requirements
- R1: Synchronous active-low reset loads the ring pointer with `tx_ring_size`, clears all events and `buf_valid`, and leaves the memory port idle. The first frame after reset uses descriptor index `tx_ring_size`.
- R2: A frame start accepted while a descriptor is empty causes two reads: the status word at `2*idx`, then the address word at `2*idx+1`. The address is then presented on `buf_addr` together with a single-cycle `buf_valid` pulse.
- R3: At frame end the engine performs exactly one write, to word `2*idx`. The written word carries the stored length in bits 31:16 and bit 15 (empty) cleared. Bits 14:8 (bit 14 interrupt enable, bit 13 wrap) are kept as read, and bits 7:0 hold the status.
- R4: The status byte copies input flags 7:4 (miss, overrun, invalid symbol, dribble) and 1:0 (CRC error, late collision). Input flags 3:2 are ignored. Bit 2 (too short) is set when length < minimum. Bit 3 (too long) is set when length > maximum, and in that case the stored length is capped at the maximum.
- R5: `len_limits` holds the minimum in bits 31:16 and the maximum in bits 15:0. A length equal to either limit is not an error, and new limit values apply to later frames.
- R6: For a descriptor with bit 14 set, a frame whose status bits 6:0 are all zero raises `ev_rxf`; any of bits 6:0 set raises `ev_rxe` instead. The miss bit 7 alone is not an error. With bit 14 clear, neither event is raised.
- R7: A frame that finds bit 15 clear raises `ev_busy`. It causes no write and no `buf_valid`, and the pointer does not move, so the next frame retries the same descriptor.
- R8: After a write the pointer moves to `idx+1`, or back to `tx_ring_size` when the descriptor's wrap bit 13 was set or `idx` is the last slot `NUM_BD-1`.
- R9: While `rx_en` is low, a frame start causes no memory access and no event. A frame already accepted completes normally if `rx_en` falls mid-frame.
- R10: A frame end that arrives before the descriptor lookup has finished is held and applied once the lookup completes.
- R11: Every event is a single-cycle pulse, and at most one event is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates new frame starts |
| tx_ring_size | input | IDX_W | Transmit descriptor count = first receive slot |
| len_limits | input | 32 | Minimum length [31:16], maximum length [15:0] |
| frame_start | input | 1 | Start-of-frame pulse from the datapath |
| frame_end | input | 1 | End-of-frame pulse from the datapath |
| frame_len | input | 16 | Frame length, valid with `frame_end` |
| frame_flags | input | 8 | Datapath error flags, valid with `frame_end` |
| buf_addr | output | 32 | Buffer address of the accepted descriptor |
| buf_valid | output | 1 | One-cycle pulse marking `buf_addr` valid |
| mem_req | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | Write (1) or read (0) for `mem_req` |
| mem_addr | output | IDX_W+1 | Descriptor memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| ev_rxf | output | 1 | Good-frame event pulse |
| ev_rxe | output | 1 | Errored-frame event pulse |
| ev_busy | output | 1 | Frame dropped, descriptor not empty |

## Verification
The hardest situations to reach from the ports are a frame end that lands while the status and address reads are still in flight, and the ring running off its last slot with no wrap bit. The bench covers the first by placing the frame end in the cycle right after the start, among other random gaps. It covers the second with a long random phase whose descriptors carry no wrap bit, so the pointer walks all the way to slot `NUM_BD-1`. Software-owned descriptors are planted at random, then returned, so that busy drops are followed by a retry of the same slot.

// File: rtl/rxwb_pkg.sv
// Shared definitions for the receive descriptor write-back engine.
// Assumes 32-bit descriptor words and a 16-bit length field.
package rxwb_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 16;
    localparam int FLAG_W   = 8;
    localparam int CTL_W    = 7;   // bits 14:8 of the status word

    localparam int BIT_EMPTY = 15;
    localparam int BIT_IRQ   = 14;
    localparam int BIT_WRAP  = 13;
    localparam int CTL_IRQ   = BIT_IRQ - 8;
    localparam int CTL_WRAP  = BIT_WRAP - 8;

    localparam int ST_TOOLONG = 3;
    localparam int ST_SHORT   = 2;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD_ST = 3'd1,
        S_CHK   = 3'd2,
        S_ADDR  = 3'd3,
        S_RECV  = 3'd4,
        S_WR    = 3'd5,
        S_DROP  = 3'd6
    } rx_state_t;

endpackage

// File: rtl/rxwb_ring_ptr.sv
// Ring pointer for the receive descriptor slots.
// Holds the current slot index. It starts at the transmit count (base)
// and wraps to base on a wrap request or past the last slot.
// Assumes base stays constant while out of reset.
module rxwb_ring_ptr #(
    parameter int NUM_BD = 128,
    localparam int IDX_W = $clog2(NUM_BD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] base,
    input  logic             advance,
    input  logic             wrap_hit,
    output logic [IDX_W-1:0] cur
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BD - 1);

    // Load base on reset, step or wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= base;
        end else if (advance) begin
            if (wrap_hit || cur == LAST)
                cur <= base;
            else
                cur <= cur + 1'b1;
        end
    end

    AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        cur >= base);  // R8

endmodule

// File: rtl/rxwb_status_enc.sv
// Status word encoder: applies the length limits, merges the datapath
// flags and builds the write-back word. Purely combinational.
// Assumes limits are minimum [31:16] and maximum [15:0].
module rxwb_status_enc
    import rxwb_pkg::*;
(
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [FLAG_W-1:0] frame_flags,
    input  logic [WORD_W-1:0] len_limits,
    input  logic [CTL_W-1:0]  ctl_bits,
    output logic [WORD_W-1:0] wb_word,
    output logic              wb_err
);

    logic [LEN_W-1:0]  min_len, max_len, stored_len;
    logic              too_short, too_long;
    logic [FLAG_W-1:0] status;
    logic              unused_flags;

    // Compare against limits and form the status byte.
    always_comb begin
        min_len    = len_limits[31:16];
        max_len    = len_limits[15:0];
        too_short  = frame_len < min_len;
        too_long   = frame_len > max_len;
        stored_len = too_long ? max_len : frame_len;
        status     = {frame_flags[7:4], too_long, too_short, frame_flags[1:0]};
        wb_word    = {stored_len, 1'b0, ctl_bits, status};
        wb_err     = |status[6:0];
    end

    assign unused_flags = ^frame_flags[ST_TOOLONG:ST_SHORT];

endmodule

// File: rtl/rxwb_seq.sv
// Frame sequencer: looks up the current descriptor on frame start,
// drops the frame when it is software-owned, holds an early frame end,
// and issues the single write-back at frame end.
// Assumes one-cycle read latency and no overlapping frames.
module rxwb_seq
    import rxwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [FLAG_W-1:0] frame_flags,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              enc_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic              word_sel,
    output logic              advance,
    output logic              wrap_hit,
    output logic [LEN_W-1:0]  len_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [WORD_W-1:0] buf_addr,
    output logic              buf_valid,
    output logic              ev_rxf,
    output logic              ev_rxe,
    output logic              ev_busy
);

    rx_state_t state, nxt;
    logic      fin_q;
    logic      desc_free;

    assign desc_free = rd_data[BIT_EMPTY];
    assign wrap_hit  = ctl_q[CTL_WRAP];

    // Next state and memory strobes.
    always_comb begin
        nxt      = state;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        word_sel = 1'b0;
        advance  = 1'b0;
        case (state)
            S_IDLE:  if (frame_start && rx_en) nxt = S_RD_ST;
            S_RD_ST: begin
                mem_req = 1'b1;
                nxt     = S_CHK;
            end
            S_CHK: begin
                if (desc_free) begin
                    mem_req  = 1'b1;
                    word_sel = 1'b1;
                    nxt      = S_ADDR;
                end else begin
                    nxt = S_DROP;
                end
            end
            S_ADDR:  nxt = S_RECV;
            S_RECV:  if (fin_q) nxt = S_WR;
            S_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                advance = 1'b1;
                nxt     = S_IDLE;
            end
            S_DROP:  if (fin_q) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Capture frame end (possibly early) with its length and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q   <= 1'b0;
            len_q   <= '0;
            flags_q <= '0;
        end else if (state == S_WR || (state == S_DROP && fin_q)) begin
            fin_q <= 1'b0;
        end else if (state != S_IDLE && frame_end) begin
            fin_q   <= 1'b1;
            len_q   <= frame_len;
            flags_q <= frame_flags;
        end
    end

    // Keep interrupt-enable and wrap bits of the accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ctl_q <= '0;
        else if (state == S_CHK && desc_free) ctl_q <= rd_data[14:8];
    end

    // Present the buffer address once it has been read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr  <= '0;
            buf_valid <= 1'b0;
        end else begin
            buf_valid <= (state == S_ADDR);
            if (state == S_ADDR) buf_addr <= rd_data;
        end
    end

    // Event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_rxf  <= 1'b0;
            ev_rxe  <= 1'b0;
            ev_busy <= 1'b0;
        end else begin
            ev_busy <= (state == S_CHK) && !desc_free;
            ev_rxf  <= (state == S_WR) && ctl_q[CTL_IRQ] && !enc_err;
            ev_rxe  <= (state == S_WR) && ctl_q[CTL_IRQ] && enc_err;
        end
    end

    AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !rx_en) |=> (state == S_IDLE));  // R9
    AST_DROP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |-> !mem_req);  // R7

endmodule

// File: rtl/rx_desc_writeback.sv
// Top of the receive descriptor write-back engine. It connects the
// ring pointer, the sequencer and the status encoder to a single-port
// descriptor memory (status word at 2*idx, address word at 2*idx+1).
// Assumes a memory with one-cycle read latency.
module rx_desc_writeback
    import rxwb_pkg::*;
#(
    parameter int NUM_BD = 128,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int MEM_AW = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [IDX_W-1:0]  tx_ring_size,
    input  logic [31:0]       len_limits,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [15:0]       frame_len,
    input  logic [7:0]        frame_flags,
    output logic [31:0]       buf_addr,
    output logic              buf_valid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ev_rxf,
    output logic              ev_rxe,
    output logic              ev_busy
);

    logic [IDX_W-1:0]  cur;
    logic              word_sel, advance, wrap_hit, enc_err;
    logic [LEN_W-1:0]  len_q;
    logic [FLAG_W-1:0] flags_q;
    logic [CTL_W-1:0]  ctl_q;

    rxwb_ring_ptr #(.NUM_BD(NUM_BD)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (tx_ring_size),
        .advance  (advance),
        .wrap_hit (wrap_hit),
        .cur      (cur)
    );

    rxwb_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_len   (frame_len),
        .frame_flags (frame_flags),
        .rd_data     (mem_rdata),
        .enc_err     (enc_err),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .word_sel    (word_sel),
        .advance     (advance),
        .wrap_hit    (wrap_hit),
        .len_q       (len_q),
        .flags_q     (flags_q),
        .ctl_q       (ctl_q),
        .buf_addr    (buf_addr),
        .buf_valid   (buf_valid),
        .ev_rxf      (ev_rxf),
        .ev_rxe      (ev_rxe),
        .ev_busy     (ev_busy)
    );

    rxwb_status_enc u_enc (
        .frame_len   (len_q),
        .frame_flags (flags_q),
        .len_limits  (len_limits),
        .ctl_bits    (ctl_q),
        .wb_word     (mem_wdata),
        .wb_err      (enc_err)
    );

    // Word address: slot index with the word-select as LSB.
    assign mem_addr = {cur, word_sel};

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_rxf, ev_rxe, ev_busy}));  // R11
    AST_WR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!mem_wdata[15] && !mem_addr[0]));  // R3
    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[31:16] <= len_limits[15:0]));  // R4
    AST_BUSY_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy |-> $stable(cur));  // R7
    AST_RXF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rxf |-> ($past(mem_we) && $past(mem_wdata[6:0]) == 7'd0));  // R6

endmodule

// File: tb/rx_desc_writeback_tb.sv
`timescale 1ns/1ps
module rx_desc_writeback_tb;

    localparam int NBD = 128;
    localparam int IW  = 7;
    localparam int AW  = 8;
    localparam int TXN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic [IW-1:0] tx_ring_size = IW'(TXN);
    logic [31:0]   len_limits = {16'd64, 16'd1536};
    logic          frame_start = 1'b0, frame_end = 1'b0;
    logic [15:0]   frame_len = '0;
    logic [7:0]    frame_flags = '0;
    logic [31:0]   buf_addr, mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          buf_valid, mem_req, mem_we, ev_rxf, ev_rxe, ev_busy;
    logic [AW-1:0] mem_addr;

    logic [31:0] mem [0:2*NBD-1];

    int total = 0, bad = 0, exp_idx = TXN;
    int n_rxf = 0, n_rxe = 0, n_busy = 0, n_bufv = 0, n_wr = 0, n_rd = 0;
    int last_wa = -1;
    logic [31:0] last_buf = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_desc_writeback #(.NUM_BD(NBD)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_ring_size(tx_ring_size),
        .len_limits(len_limits), .frame_start(frame_start), .frame_end(frame_end),
        .frame_len(frame_len), .frame_flags(frame_flags), .buf_addr(buf_addr),
        .buf_valid(buf_valid), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ev_rxf(ev_rxf), .ev_rxe(ev_rxe), .ev_busy(ev_busy)
    );

    // Descriptor memory model, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_rxf)  n_rxf++;
            if (ev_rxe)  n_rxe++;
            if (ev_busy) n_busy++;
            if (buf_valid) begin n_bufv++; last_buf = buf_addr; end
            if (mem_req && mem_we)  begin n_wr++; last_wa = int'(mem_addr); end
            if (mem_req && !mem_we) n_rd++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] prior,
            input logic [15:0] len, input logic [7:0] fl, input logic [31:0] lim);
        logic ts, tl;
        logic [15:0] sl;
        ts = len < lim[31:16];
        tl = len > lim[15:0];
        sl = tl ? lim[15:0] : len;
        return {sl, 1'b0, prior[14:8], fl[7:4], tl, ts, fl[1:0]};
    endfunction

    task automatic arm(input int idx, input bit irq, input bit wrap);
        mem[2*idx]   = {16'h0, 1'b1, irq, wrap, 5'h0, 8'h0};
        mem[2*idx+1] = 32'hB000_0000 + 32'(idx) * 32'h800;
    endtask

    // One frame: start, gap cycles, end; then check against the model.
    task automatic frame(input logic [15:0] len, input logic [7:0] fl,
                         input int gap, input bit drop_en);
        int idx;
        logic [31:0] prior, baddr, expw;
        int s_rxf, s_rxe, s_busy, s_bufv, s_wr;
        bit err;
        idx = exp_idx; prior = mem[2*idx]; baddr = mem[2*idx+1];
        s_rxf = n_rxf; s_rxe = n_rxe; s_busy = n_busy; s_bufv = n_bufv; s_wr = n_wr;
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        if (drop_en) rx_en = 1'b0;
        repeat (gap) @(negedge clk);
        frame_end = 1'b1; frame_len = len; frame_flags = fl;
        @(negedge clk) frame_end = 1'b0;
        repeat (12) @(negedge clk);
        if (!prior[15]) begin
            chk(n_busy - s_busy == 1, "R7 busy event", n_busy - s_busy, 1);
            chk(n_wr == s_wr && n_bufv == s_bufv, "R7 no write/buffer",
                n_wr - s_wr, 0);
            chk(mem[2*idx] == prior, "R7 descriptor untouched", mem[2*idx], prior);
            mem[2*idx][15] = 1'b1;   // software returns it; same slot retried
        end else begin
            expw = exp_word(prior, len, fl, len_limits);
            err  = |expw[6:0];
            chk(n_bufv - s_bufv == 1 && last_buf == baddr, "R2 buffer address",
                last_buf, baddr);
            chk(n_wr - s_wr == 1 && last_wa == 2*idx, "R3/R8 write slot",
                last_wa, 2*idx);
            chk(mem[2*idx] == expw, "R3/R4 written word", mem[2*idx], expw);
            chk(n_rxf - s_rxf == ((prior[14] && !err) ? 1 : 0) &&
                n_rxe - s_rxe == ((prior[14] && err) ? 1 : 0) &&
                n_busy == s_busy, "R6 events",
                {n_rxf - s_rxf, n_rxe - s_rxe}, {prior[14] && !err, prior[14] && err});
            exp_idx = (prior[13] || idx == NBD-1) ? TXN : idx + 1;
            mem[2*idx] = {16'h0, 1'b1, prior[14:8], 8'h0};
        end
        if (drop_en) rx_en = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0, s1;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 2*NBD; i++) mem[i] = '0;
        for (int i = TXN; i < NBD; i++) arm(i, 1'b1, 1'b0);
        arm(13, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!mem_req && !buf_valid && !ev_rxf && !ev_rxe && !ev_busy,
            "R1 reset outputs", {mem_req, buf_valid, ev_rxf, ev_rxe, ev_busy}, 0);
        rst_n = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        frame(16'd100, 8'h00, 3, 0);           // R1 first slot, R2, R3
        frame(16'd40,  8'h00, 2, 0);           // R4 too short
        frame(16'd64,  8'h00, 1, 0);           // R5 equal to minimum
        frame(16'd1536, 8'h00, 4, 0);          // R5 equal to maximum
        frame(16'd1600, 8'h00, 2, 0);          // R4 capped
        frame(16'd200, 8'h0C, 2, 0);           // R4 inputs 3:2 ignored, R8 wrap at 13
        frame(16'd200, 8'h80, 2, 0);           // R6 miss alone is good
        frame(16'd200, 8'h02, 2, 0);           // R6 CRC error
        mem[2*exp_idx][14] = 1'b0;
        frame(16'd300, 8'h00, 2, 0);           // R6 no event with irq clear
        mem[2*(exp_idx == TXN ? 13 : exp_idx-1)][14] = 1'b1;
        mem[2*exp_idx][15] = 1'b0;
        frame(16'd300, 8'h00, 2, 0);           // R7 busy drop
        frame(16'd300, 8'h00, 2, 0);           // R7 retry same slot
        // R9: starts ignored while disabled
        rx_en = 1'b0; s0 = n_rd; s1 = n_rxf + n_rxe + n_busy;
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_rd == s0 && n_rxf + n_rxe + n_busy == s1, "R9 start ignored",
            n_rd - s0, 0);
        rx_en = 1'b1;
        frame(16'd500, 8'h00, 3, 1);           // R9 completes after disable
        frame(16'd500, 8'h00, 0, 0);           // R10 early end
        frame(16'd70,  8'h40, 0, 0);           // R10 early end, errored
        len_limits = {16'd100, 16'd200};
        frame(16'd99,  8'h00, 2, 0);           // R5 new minimum
        frame(16'd201, 8'h00, 2, 0);           // R5 new maximum, capped
        frame(16'd100, 8'h00, 2, 0);           // R5 boundary good
        // Random phase: no wrap bits, ring runs to last slot (R8).
        len_limits = {16'd64, 16'd1536};
        mem[2*13][13] = 1'b0;
        for (int k = 0; k < 160; k++) begin
            logic [15:0] ln;
            logic [7:0]  fl;
            ln = 16'(20 + $urandom % 1700);
            fl = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
            if ($urandom % 10 == 0) mem[2*exp_idx][15] = 1'b0;
            mem[2*exp_idx][14] = ($urandom % 8 != 0);
            frame(ln, fl, int'($urandom % 6), 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule